// File: doc/BRIEF.md
# Memory-Mapped Serial Port

This block is a bus slave that gives a processor a byte-wide asynchronous serial link through two word locations in its I/O space. A store to the data word hands the low byte of the write data to a transmitter, which sends it as one frame on the TX pin. A load from that same word returns the last byte taken off the RX pin. A second word, which software can only read, reports whether the transmitter is still sending and whether a received byte is waiting.

Each frame has a low start bit, eight data bits sent least significant bit first, no parity bit and one high stop bit. The line rate comes from two parameters, the clock frequency and the baud rate (115200 by default). From them the block derives a divider for an oversampling tick at sixteen times the bit rate. The receiver passes the line through a two-flop synchronizer. It then uses that tick to place its samples in the middle of each bit. Every bus access completes in the cycle it is presented.

Top module: `mmio_serial_port`

## Requirements
- R1: A write to offset 0x0 while the transmitter is idle starts a frame in the next cycle: TX low for one bit period, then write-data bits 0 to 7 in that order, then TX high for one bit period. Each bit lasts 16*DIV cycles, where DIV = CLK_HZ/(16*BAUD).
- R2: TX is high whenever the transmitter is idle, including straight after reset.
- R3: Status bit 0 (busy) reads 1 from the cycle after an accepted data write for exactly ten bit periods, then reads 0.
- R4: A write to offset 0x0 while busy is ignored, and the frame in progress continues unchanged.
- R5: busReady equals busValid in every cycle, so every access completes in one cycle.
- R6: A read of offset 0x4 returns bit 0 = busy and bit 1 = receive-available, with bits 31 to 2 zero. A write to offset 0x4 has no effect.
- R7: A frame received with a high stop bit sets status bit 1, and a read of offset 0x0 returns that byte in bits 7 to 0, with bits 31 to 8 zero.
- R8: A read of offset 0x0 clears status bit 1. The byte stays readable afterwards.
- R9: A byte that arrives before the previous one is read replaces it.
- R10: A low pulse on RX that ends before the half-bit check (8 oversampling ticks after detection) is rejected and produces no byte.
- R11: A frame whose stop bit samples low is discarded: status bit 1 stays 0.
- R12: After reset, the status word and the data word both read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| busValid | input | 1 | Access request |
| busWrite | input | 1 | 1 = store, 0 = load |
| busAddr | input | ADDR_W | Byte offset (0x0 data, 0x4 status) |
| busWdata | input | 32 | Store data; bits 7:0 go to the transmitter |
| busReady | output | 1 | Access complete |
| busRdata | output | 32 | Load data, valid while busValid is high and busWrite is low |
| rxPin | input | 1 | Serial receive line |
| txPin | output | 1 | Serial transmit line |

## Verification
The receive corner cases are the hardest to reach from the ports. These are a start glitch that must die at the half-bit check, a stop bit that samples low, and a second byte that lands on an unread first one. The bench shapes the RX waveform cycle by cycle to produce each of them. For the glitch it holds the line low for a quarter bit. For the bad frame it drives a low stop bit. For the overwrite it sends two frames back to back and reads neither in between. A behavioural model of the transmitter runs alongside the design and checks the TX pin and the busy bit on every clock. This covers the stores made while a frame is in flight.

// File: rtl/mmio_serial_pkg.sv
package mmio_serial_pkg;

  // strobes issued by the bus-side control to the serial engines
  typedef struct packed {
    logic       txLoad;
    logic [7:0] txData;
  } ctrl_strobe_t;

  // engine state reported back to the control
  typedef struct packed {
    logic       txBusy;
    logic       rxDone;
    logic [7:0] rxByte;
  } dp_status_t;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_t;

endpackage

// File: rtl/serial_ctrl.sv
module serial_ctrl
  import mmio_serial_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic              busReady,
  output logic [31:0]       busRdata,
  input  dp_status_t        dpStat,
  output ctrl_strobe_t      strobe,
  output logic              rxAvail
);

  localparam int SEL_W = ADDR_W - 2;

  logic [SEL_W-1:0] wordSel;
  logic             selData;
  logic             selStat;
  logic             readData;
  logic [7:0]       rxHeld;

  assign wordSel  = busAddr[ADDR_W-1:2];
  assign selData  = (wordSel == SEL_W'(0));
  assign selStat  = (wordSel == SEL_W'(1));
  assign readData = busValid && !busWrite && selData;

  // single-cycle access
  assign busReady = busValid;

  always_comb begin
    strobe.txLoad = busValid && busWrite && selData && !dpStat.txBusy;
    strobe.txData = busWdata[7:0];
  end

  always_comb begin
    busRdata = '0;
    if (busValid && !busWrite) begin
      if (selData)      busRdata = {24'd0, rxHeld};
      else if (selStat) busRdata = {30'd0, rxAvail, dpStat.txBusy};
    end
  end

  // a newly delivered byte wins over a clearing read in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      rxHeld  <= '0;
      rxAvail <= 1'b0;
    end else if (dpStat.rxDone) begin
      rxHeld  <= dpStat.rxByte;
      rxAvail <= 1'b1;
    end else if (readData) begin
      rxAvail <= 1'b0;
    end
  end

endmodule

// File: rtl/serial_datapath.sv
module serial_datapath
  import mmio_serial_pkg::*;
#(
  parameter int DIV         = 54,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  ctrl_strobe_t strobe,
  input  logic         rxPin,
  output logic         txPin,
  output dp_status_t   dpStat
);

  localparam int OVS     = 16;
  localparam int HALF    = OVS / 2;
  localparam int BIT_CYC = OVS * DIV;
  localparam int TCNT_W  = $clog2(BIT_CYC);
  localparam int DIV_W   = $clog2(DIV + 1);
  localparam int FRAME   = 10;

  // ---------------- transmitter ----------------
  logic [FRAME-1:0]  txShift;
  logic [TCNT_W-1:0] txCnt;
  logic [3:0]        txIdx;
  logic              txBusy;

  always_ff @(posedge clk) begin
    if (rst) begin
      txShift <= '1;
      txCnt   <= '0;
      txIdx   <= '0;
      txBusy  <= 1'b0;
    end else if (!txBusy) begin
      if (strobe.txLoad) begin
        txShift <= {1'b1, strobe.txData, 1'b0};
        txCnt   <= '0;
        txIdx   <= '0;
        txBusy  <= 1'b1;
      end
    end else if (txCnt == TCNT_W'(BIT_CYC - 1)) begin
      txCnt <= '0;
      if (txIdx == 4'(FRAME - 1)) begin
        txBusy <= 1'b0;
      end else begin
        txIdx   <= txIdx + 4'd1;
        txShift <= {1'b1, txShift[FRAME-1:1]};
      end
    end else begin
      txCnt <= txCnt + TCNT_W'(1);
    end
  end

  assign txPin = txBusy ? txShift[0] : 1'b1;

  // ---------------- receiver ----------------
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   rxSync;

  always_ff @(posedge clk) begin
    if (rst) syncQ <= '1;
    else     syncQ <= {syncQ[SYNC_STAGES-2:0], rxPin};
  end
  assign rxSync = syncQ[SYNC_STAGES-1];

  rx_state_t        rxState;
  logic [DIV_W-1:0] divCnt;
  logic [3:0]       tickCnt;
  logic [2:0]       bitCnt;
  logic [7:0]       rxShift;
  logic             rxDone;
  logic             rxTick;

  assign rxTick = (divCnt == DIV_W'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      rxState <= RX_IDLE;
      divCnt  <= '0;
      tickCnt <= '0;
      bitCnt  <= '0;
      rxShift <= '0;
      rxDone  <= 1'b0;
    end else begin
      rxDone <= 1'b0;
      if (rxState == RX_IDLE) begin
        divCnt  <= '0;
        tickCnt <= '0;
        if (!rxSync) rxState <= RX_START;
      end else begin
        divCnt <= rxTick ? '0 : divCnt + DIV_W'(1);
        if (rxTick) begin
          unique case (rxState)
            RX_START: begin
              if (tickCnt == 4'(HALF - 1)) begin
                tickCnt <= '0;
                bitCnt  <= '0;
                rxState <= rxSync ? RX_IDLE : RX_DATA;
              end else begin
                tickCnt <= tickCnt + 4'd1;
              end
            end
            RX_DATA: begin
              tickCnt <= tickCnt + 4'd1;
              if (tickCnt == 4'(OVS - 1)) begin
                rxShift <= {rxSync, rxShift[7:1]};
                if (bitCnt == 3'd7) rxState <= RX_STOP;
                else                bitCnt  <= bitCnt + 3'd1;
              end
            end
            RX_STOP: begin
              tickCnt <= tickCnt + 4'd1;
              if (tickCnt == 4'(OVS - 1)) begin
                rxState <= RX_IDLE;
                rxDone  <= rxSync;
              end
            end
            default: rxState <= RX_IDLE;
          endcase
        end
      end
    end
  end

  always_comb begin
    dpStat.txBusy = txBusy;
    dpStat.rxDone = rxDone;
    dpStat.rxByte = rxShift;
  end

endmodule

// File: rtl/mmio_serial_port.sv
module mmio_serial_port
  import mmio_serial_pkg::*;
#(
  parameter int CLK_HZ = 100_000_000,
  parameter int BAUD   = 115_200,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic              busReady,
  output logic [31:0]       busRdata,
  input  logic              rxPin,
  output logic              txPin
);

  localparam int RAW_DIV = CLK_HZ / (BAUD * 16);
  localparam int DIV     = (RAW_DIV < 1) ? 1 : RAW_DIV;

  ctrl_strobe_t strobe;
  dp_status_t   dpStat;
  logic         rxAvail;
  logic         txBusy;
  logic         rxDone;

  assign txBusy = dpStat.txBusy;
  assign rxDone = dpStat.rxDone;

  serial_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busReady (busReady),
    .busRdata (busRdata),
    .dpStat   (dpStat),
    .strobe   (strobe),
    .rxAvail  (rxAvail)
  );

  serial_datapath #(.DIV(DIV), .SYNC_STAGES(2)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .rxPin  (rxPin),
    .txPin  (txPin),
    .dpStat (dpStat)
  );

endmodule

// File: rtl/serial_checker.sv
module serial_checker #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busReady,
  input logic [31:0]       busRdata,
  input logic              txPin,
  input logic              txBusy,
  input logic              rxDone,
  input logic              rxAvail
);

  logic dataSel;
  logic statSel;
  assign dataSel = (busAddr[ADDR_W-1:2] == '0);
  assign statSel = (busAddr[ADDR_W-1:2] == (ADDR_W-2)'(1));

  assert_idle_high_R2: assert property (@(posedge clk) disable iff (rst)
    !txBusy |-> txPin);

  assert_start_low_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(txBusy) |-> !txPin);

  assert_busy_write_R4: assert property (@(posedge clk) disable iff (rst)
    (txBusy && !txPin && busValid && busWrite && dataSel && $past(txBusy)) |=> (txBusy || txPin));

  assert_one_cycle_R5: assert property (@(posedge clk) disable iff (rst)
    busValid |-> busReady);

  assert_status_upper_R6: assert property (@(posedge clk) disable iff (rst)
    (busValid && !busWrite && statSel) |-> (busRdata[31:2] == 30'd0));

  assert_rx_sets_R7: assert property (@(posedge clk) disable iff (rst)
    rxDone |=> rxAvail);

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (rxAvail && busValid && !busWrite && dataSel && !rxDone) |=> !rxAvail);

endmodule

bind mmio_serial_port serial_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busValid (busValid),
  .busWrite (busWrite),
  .busAddr  (busAddr),
  .busReady (busReady),
  .busRdata (busRdata),
  .txPin    (txPin),
  .txBusy   (txBusy),
  .rxDone   (rxDone),
  .rxAvail  (rxAvail)
);

// File: tb/mmio_serial_port_bench.sv
module mmio_serial_port_bench;

  localparam int CLK_HZ = 100_000_000;
  localparam int BAUD   = 1_562_500;
  localparam int DIV    = CLK_HZ / (BAUD * 16);
  localparam int BIT    = 16 * DIV;
  localparam int FRAME  = 10 * BIT;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        busReady;
  logic [31:0] busRdata;
  logic        rxPin = 1'b1;
  logic        txPin;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  mmio_serial_port #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .ADDR_W(3)) u_mmio_serial_port (
    .clk(clk), .rst(rst), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busReady(busReady),
    .busRdata(busRdata), .rxPin(rxPin), .txPin(txPin)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural transmitter model: cycles left in the current frame
  int         txRemain = 0;
  logic [9:0] txFrame  = '1;

  always @(posedge clk) begin
    if (rst) txRemain <= 0;
    else if (txRemain > 0) txRemain <= txRemain - 1;
    else if (busValid && busWrite && busAddr[2] == 1'b0) begin
      txRemain <= FRAME;
      txFrame  <= {1'b1, busWdata[7:0], 1'b0};
    end
  end

  // every-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      logic expLine;
      expLine = (txRemain > 0) ? txFrame[(FRAME - txRemain) / BIT] : 1'b1;
      chk("R1/R2 tx line", {31'd0, txPin}, {31'd0, expLine});
      chk("R5 ready", {31'd0, busReady}, {31'd0, busValid});
      if (busValid && !busWrite && busAddr[2]) begin
        chk("R3 busy bit", {31'd0, busRdata[0]}, {31'd0, txRemain > 0});
        chk("R6 upper zero", {2'd0, busRdata[31:2]}, 32'd0);
      end
    end
  end

  task automatic busWr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); #2;
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [2:0] a, output logic [31:0] d);
    @(posedge clk); #2;
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    @(negedge clk);
    d = busRdata;
    @(posedge clk); #2;
    busValid = 1'b0;
  endtask

  task automatic holdBit(input logic v);
    rxPin = v;
    repeat (BIT) @(posedge clk);
    #2;
  endtask

  task automatic rxSend(input logic [7:0] b, input logic stopVal);
    @(posedge clk); #2;
    holdBit(1'b0);
    for (int i = 0; i < 8; i++) holdBit(b[i]);
    holdBit(stopVal);
    holdBit(1'b1);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (190_000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    logic [31:0] r;
    repeat (4) @(posedge clk);
    #2 rst = 1'b0;

    // R12 reset state
    busRd(3'h4, r); chk("R12 status after reset", r, 32'd0);
    busRd(3'h0, r); chk("R12 data after reset", r, 32'd0);

    // R1 frame, R3 busy, R4 write while busy
    busWr(3'h0, 32'h0000_00A5);
    busRd(3'h4, r); chk("R3 busy during frame", r, 32'd1);
    busWr(3'h0, 32'h0000_003C);
    repeat (FRAME) @(posedge clk);
    busRd(3'h4, r); chk("R3 busy cleared after frame", r, 32'd0);

    // R1 second frame, upper write bits ignored
    busWr(3'h0, 32'hFFFF_FF80);
    repeat (FRAME + 2) @(posedge clk);

    // R6 write to status has no effect
    busWr(3'h4, 32'hFFFF_FFFF);
    busRd(3'h4, r); chk("R6 status write ignored", r, 32'd0);
    chk("R6 line idle", {31'd0, txPin}, 32'd1);

    // R7 receive, R8 clear on read
    rxSend(8'h5A, 1'b1);
    busRd(3'h4, r); chk("R7 avail set", r, 32'd2);
    busRd(3'h0, r); chk("R7 data", r, 32'h5A);
    busRd(3'h4, r); chk("R8 avail cleared", r, 32'd0);
    busRd(3'h0, r); chk("R8 byte kept", r, 32'h5A);

    // R9 overwrite
    rxSend(8'h11, 1'b1);
    rxSend(8'h22, 1'b1);
    busRd(3'h0, r); chk("R9 newest byte", r, 32'h22);
    busRd(3'h4, r); chk("R9 cleared", r, 32'd0);

    // R10 short start glitch
    @(posedge clk); #2;
    rxPin = 1'b0;
    repeat (BIT / 4) @(posedge clk);
    #2 rxPin = 1'b1;
    repeat (11 * BIT) @(posedge clk);
    busRd(3'h4, r); chk("R10 glitch rejected", r, 32'd0);
    busRd(3'h0, r); chk("R10 data unchanged", r, 32'h22);

    // R11 bad stop bit
    rxSend(8'h77, 1'b0);
    repeat (BIT) @(posedge clk);
    busRd(3'h4, r); chk("R11 frame discarded", r, 32'd0);
    busRd(3'h0, r); chk("R11 data unchanged", r, 32'h22);

    // R7 recovery after discarded frame
    rxSend(8'h42, 1'b1);
    busRd(3'h4, r); chk("R7 avail after recovery", r, 32'd2);
    busRd(3'h0, r); chk("R7 data after recovery", r, 32'h42);

    repeat (4) @(posedge clk);
    finishRun();
  end

endmodule